// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous internal request port and an external asynchronous static RAM with an 18-bit word address and a 16-bit bidirectional data bus made of two byte lanes. Each accepted request becomes a fixed sequence of active-low strobes on the RAM pins: chip select, write strobe, output enable and one enable per byte lane. The block also owns the tri-state drive of the data bus, so the bus is never driven while the RAM may be driving it.

The RAM's timing limits (access time, read and write cycle time, write pulse width, data setup and the power-up wait) are given as nanosecond parameters together with the clock period. At elaboration each limit is converted to a whole number of clock cycles. A request is taken only while `ready` is high. Read data is returned with a one-cycle `rd_valid` pulse. After reset the block holds `ready` low until the power-up wait has passed.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset is released, `ready` stays low and the chip select stays high for exactly ceil(T_PWRUP_NS/CLK_NS) rising edges. `ready` is high in the cycle that follows.
- R2: While reset is asserted, chip select, write strobe, output enable and both lane enables are high (inactive), `rd_valid` is low and `rd_data` is zero.
- R3: An accepted write runs one setup cycle (chip select low, write strobe high), then P cycles with the write strobe low, then H cycles with chip select low and the write strobe high, and then returns to idle. Output enable stays high for the whole sequence.
- R4: During a write the data bus carries the request's write data from the second write-strobe-low cycle through the first cycle after the write strobe rises. This gives at least ceil(T_SD_NS/CLK_NS) cycles of stable data before the strobe rises, and one cycle of hold after it.
- R5: Request lane bit 0 selects data bits 7:0 and drives `ram_be_n[0]` low. Bit 1 selects bits 15:8 and drives `ram_be_n[1]` low. A write changes only the selected lanes, and a write with neither lane selected leaves memory unchanged.
- R6: An accepted read holds chip select and output enable low with the write strobe high for A = max(ceil(T_AA_NS/CLK_NS), ceil(T_RC_NS/CLK_NS)) cycles. One turnaround cycle follows with chip select low and output enable high.
- R7: `rd_valid` is high for exactly the turnaround cycle of each read. In that cycle `rd_data` holds the RAM data sampled on the last access cycle in the selected lanes and zero in the unselected lanes.
- R8: Address and lane enables stay constant from the first cycle of a sequence through its last cycle, which lies at least one cycle past the end of every strobe.
- R9: `ready` is high only while the block is idle and the power-up wait is over. A request made while `ready` is low produces no strobe activity.
- R10: Each timing limit is rounded up to whole cycles with a minimum of one. The write pulse uses P = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)+1) and the hold uses H = max(1, ceil(T_WC_NS/CLK_NS)-1-P).

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Request accepted on the next rising edge if req_valid is high |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| rd_data | output | 16 | Read data |
| ram_addr | output | 18 | RAM address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM lane enables, active low, bit 0 = low lane |
| ram_dq | inout | 16 | RAM data bus |

## Verification
The assertions check several properties on every cycle. No strobe may appear before the power-up wait ends. Output enable must stay high whenever the write strobe is low. The bus may be driven only with chip select low and output enable high, and never in the first write-strobe-low cycle. Address and lane enables must hold steady across consecutive selected cycles. `ready` must imply an idle bus, and `rd_valid` must be a single pulse that directly follows an output-enable window. Some results can only be shown by the bench's scenarios, which run against a RAM model that returns wrong data until the access time has passed. These are the exact cycle counts of each sequence for slow-grade timings, correct lane merging of partial writes on readback, that requests made while busy or during power-up are ignored, and that write data meets its setup and hold at the moment the write ends.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } seq_state_e;

    // Round a time in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_pwrup.sv
module sramc_pwrup #(
    parameter int unsigned WAIT_C = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int unsigned CW = $clog2(WAIT_C + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          done_d, done_q;

    always_comb begin
        cnt_d  = cnt_q;
        done_d = done_q;
        if (!done_q) begin
            cnt_d  = cnt_q + 1'b1;
            done_d = (cnt_q == CW'(WAIT_C - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/sramc_lane.sv
module sramc_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [LANE_W-1:0] wbyte_i,
    input  logic              drive_i,
    input  logic              capture_i,
    input  logic              en_i,
    inout  wire  [LANE_W-1:0] pad,
    output logic [LANE_W-1:0] rbyte_o
);
    logic [LANE_W-1:0] wbyte_d, wbyte_q;
    logic [LANE_W-1:0] rbyte_d, rbyte_q;

    always_comb begin
        wbyte_d = load_i ? wbyte_i : wbyte_q;
        rbyte_d = rbyte_q;
        if (capture_i) begin
            rbyte_d = en_i ? pad : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbyte_q <= '0;
            rbyte_q <= '0;
        end else begin
            wbyte_q <= wbyte_d;
            rbyte_q <= rbyte_d;
        end
    end

    // Bus drive comes from a register in the sequencer, so it is glitch free.
    assign pad     = drive_i ? wbyte_q : {LANE_W{1'bz}};
    assign rbyte_o = rbyte_q;
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned LANES   = 2,
    parameter int unsigned PULSE_C = 2,
    parameter int unsigned HOLD_C  = 1,
    parameter int unsigned ACC_C   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_i,
    output logic              ce_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [LANES-1:0]  be_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drv_o,
    output logic              load_o,
    output logic              capture_o,
    output logic              rdv_o,
    output logic              idle_o
);
    localparam int unsigned CMAX = max2(max2(PULSE_C, HOLD_C), ACC_C);
    localparam int unsigned CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be_n;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              rdv;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      take;

    assign take = (r_q.st == ST_IDLE) && start_i;

    always_comb begin
        r_d     = r_q;
        r_d.rdv = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (take) begin
                    r_d.addr = addr_i;
                    r_d.be_n = ~be_i;
                    if (write_i) begin
                        r_d.st  = ST_WSETUP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.st  = ST_RACC;
                        r_d.cnt = CNT_W'(ACC_C - 1);
                    end
                end
            end
            ST_WSETUP: begin
                r_d.st  = ST_WPULSE;
                r_d.cnt = CNT_W'(PULSE_C - 1);
            end
            ST_WPULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_WHOLD;
                    r_d.cnt = CNT_W'(HOLD_C - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (r_q.cnt == '0) r_d.st = ST_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_RACC: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RTURN;
                    r_d.rdv = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RTURN: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase

        // Pin values are registered from the next state.
        r_d.ce_n = (r_d.st == ST_IDLE);
        r_d.we_n = (r_d.st != ST_WPULSE);
        r_d.oe_n = (r_d.st != ST_RACC);
        r_d.drv  = ((r_d.st == ST_WPULSE) && (r_d.cnt != CNT_W'(PULSE_C - 1)))
                || ((r_d.st == ST_WHOLD) && (r_q.st == ST_WPULSE));
        if (r_d.st == ST_IDLE) r_d.be_n = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.addr <= '0;
            r_q.be_n <= '1;
            r_q.ce_n <= 1'b1;
            r_q.we_n <= 1'b1;
            r_q.oe_n <= 1'b1;
            r_q.drv  <= 1'b0;
            r_q.rdv  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ce_n_o    = r_q.ce_n;
    assign we_n_o    = r_q.we_n;
    assign oe_n_o    = r_q.oe_n;
    assign be_n_o    = r_q.be_n;
    assign addr_o    = r_q.addr;
    assign drv_o     = r_q.drv;
    assign rdv_o     = r_q.rdv;
    assign load_o    = take && write_i;
    assign capture_o = (r_q.st == ST_RACC) && (r_q.cnt == '0);
    assign idle_o    = (r_q.st == ST_IDLE);
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned LANE_W     = 8,
    parameter int unsigned CLK_NS     = 20,
    parameter int unsigned T_RC_NS    = 10,
    parameter int unsigned T_AA_NS    = 10,
    parameter int unsigned T_WC_NS    = 10,
    parameter int unsigned T_PWE_NS   = 7,
    parameter int unsigned T_SD_NS    = 5,
    parameter int unsigned T_PWRUP_NS = 100000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     ready,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic                     ram_ce_n,
    output logic                     ram_we_n,
    output logic                     ram_oe_n,
    output logic [DATA_W/LANE_W-1:0] ram_be_n,
    inout  wire  [DATA_W-1:0]        ram_dq
);
    localparam int unsigned LANES   = DATA_W / LANE_W;
    localparam int unsigned RC_C    = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int unsigned AA_C    = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int unsigned WC_C    = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int unsigned PWE_C   = ns_to_cycles(T_PWE_NS, CLK_NS);
    localparam int unsigned SD_C    = ns_to_cycles(T_SD_NS, CLK_NS);
    localparam int unsigned PWR_C   = ns_to_cycles(T_PWRUP_NS, CLK_NS);
    // Drive starts one cycle after the strobe falls, so setup needs one more.
    localparam int unsigned PULSE_C = max2(PWE_C, SD_C + 1);
    localparam int unsigned HOLD_C  = (WC_C > PULSE_C + 2) ? (WC_C - 1 - PULSE_C) : 1;
    localparam int unsigned ACC_C   = max2(AA_C, RC_C);

    logic pwr_done;
    logic seq_idle;
    logic bus_drv;
    logic wr_load;
    logic rd_capture;

    sramc_pwrup #(.WAIT_C(PWR_C)) u_pwrup (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (pwr_done)
    );

    sramc_seq #(
        .ADDR_W  (ADDR_W),
        .LANES   (LANES),
        .PULSE_C (PULSE_C),
        .HOLD_C  (HOLD_C),
        .ACC_C   (ACC_C)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (req_valid && pwr_done),
        .write_i   (req_write),
        .addr_i    (req_addr),
        .be_i      (req_be),
        .ce_n_o    (ram_ce_n),
        .we_n_o    (ram_we_n),
        .oe_n_o    (ram_oe_n),
        .be_n_o    (ram_be_n),
        .addr_o    (ram_addr),
        .drv_o     (bus_drv),
        .load_o    (wr_load),
        .capture_o (rd_capture),
        .rdv_o     (rd_valid),
        .idle_o    (seq_idle)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sramc_lane #(.LANE_W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (wr_load),
            .wbyte_i   (req_wdata[i*LANE_W +: LANE_W]),
            .drive_i   (bus_drv),
            .capture_i (rd_capture),
            .en_i      (~ram_be_n[i]),
            .pad       (ram_dq[i*LANE_W +: LANE_W]),
            .rbyte_o   (rd_data[i*LANE_W +: LANE_W])
        );
    end

    assign ready = pwr_done && seq_idle;
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic              ram_ce_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic [LANES-1:0]  ram_be_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              drv,
    input logic              pwr_done
);
    a_r1_quiet_before_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> (ram_ce_n && !ready));

    a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (ram_oe_n && !ram_ce_n));

    a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> (ram_oe_n && !ram_ce_n));

    a_r4_no_drive_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> !drv);

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_be_n)));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (ram_oe_n && $past(!ram_oe_n)));

    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ram_ce_n && ram_we_n && ram_oe_n));
endmodule

bind sramc_ctrl sramc_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rd_valid (rd_valid),
    .ram_ce_n (ram_ce_n),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .ram_be_n (ram_be_n),
    .ram_addr (ram_addr),
    .drv      (bus_drv),
    .pwr_done (pwr_done)
);

// File: tb/sramc_ctrl_bench.sv
`timescale 1ns/1ps
module sramc_ctrl_bench;
    localparam int CLKP = 20;
    localparam int TAA = 45, TRC = 45, TWC = 110, TPWE = 30, TSD = 25, TPWR = 100000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLKP - 1) / CLKP;
        return (c < 1) ? 1 : c;
    endfunction

    // R10: rounded cycle counts and derived pulse / hold lengths
    localparam int AA_C  = cyc(TAA);
    localparam int ACC_C = (cyc(TAA) > cyc(TRC)) ? cyc(TAA) : cyc(TRC);
    localparam int PWE_C = cyc(TPWE);
    localparam int SD_C  = cyc(TSD);
    localparam int PW_C  = cyc(TPWR);
    localparam int P_C   = (PWE_C > SD_C + 1) ? PWE_C : SD_C + 1;
    localparam int H_C   = (cyc(TWC) - 1 - P_C > 1) ? cyc(TWC) - 1 - P_C : 1;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [17:0] req_addr = 0;
    logic [1:0]  req_be = 0;
    logic [15:0] req_wdata = 0;
    logic        ready, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] ram_addr;
    logic        ram_ce_n, ram_we_n, ram_oe_n;
    logic [1:0]  ram_be_n;
    wire  [15:0] ram_dq;

    always #(CLKP/2) clk = ~clk;

    sramc_ctrl #(
        .CLK_NS(CLKP), .T_RC_NS(TRC), .T_AA_NS(TAA), .T_WC_NS(TWC),
        .T_PWE_NS(TPWE), .T_SD_NS(TSD), .T_PWRUP_NS(TPWR)
    ) u_sramc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq(ram_dq)
    );

    int nchk = 0, nfail = 0, ecnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural RAM model ----------------
    logic [15:0] ram_mem [0:262143];
    logic [15:0] ref_mem [0:262143];
    int          rcnt = 0;
    logic [17:0] r_addr = 0;
    logic        rd_act;
    assign rd_act = !ram_ce_n && !ram_oe_n && ram_we_n;

    for (genvar l = 0; l < 2; l++) begin : g_model
        // Returns wrong (inverted) data until the access time has passed.
        assign ram_dq[l*8 +: 8] = (rd_act && !ram_be_n[l])
            ? ((rcnt >= AA_C) ? ram_mem[ram_addr][l*8 +: 8] : ~ram_mem[ram_addr][l*8 +: 8])
            : 8'hzz;
    end

    bit          prev_w = 0;
    int          wcnt = 0, stab = 0;
    logic [15:0] last_dq = 0;
    logic [17:0] w_addr = 0;
    logic [1:0]  w_be = 0;

    // ---------------- reference sequence model ----------------
    typedef struct packed {
        logic        ce_n, we_n, oe_n;
        logic [1:0]  be_n;
        logic [17:0] addr;
        logic        dchk;
        logic [15:0] wd;
        logic        rdv;
        logic [15:0] rd;
    } exp_t;

    exp_t q[$];

    task automatic push_seq(input bit w, input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
        exp_t e;
        logic [15:0] m;
        e = '0; e.ce_n = 0; e.we_n = 1; e.oe_n = 1; e.be_n = ~be; e.addr = a; e.wd = d;
        if (w) begin
            q.push_back(e);                                  // R3 setup
            for (int i = 0; i < P_C; i++) begin              // R3 pulse, R4 drive
                e.we_n = 0; e.dchk = (i >= 1); q.push_back(e);
            end
            for (int j = 0; j < H_C; j++) begin              // R3 hold, R4 hold
                e.we_n = 1; e.dchk = (j == 0); q.push_back(e);
            end
            m = ref_mem[a];                                  // R5 lane merge
            if (be[0]) m[7:0]  = d[7:0];
            if (be[1]) m[15:8] = d[15:8];
            ref_mem[a] = m;
        end else begin
            for (int i = 0; i < ACC_C; i++) begin            // R6 access window
                e.oe_n = 0; q.push_back(e);
            end
            e.oe_n = 1; e.rdv = 1;                           // R7 turnaround
            m = ref_mem[a];
            e.rd = {be[1] ? m[15:8] : 8'h00, be[0] ? m[7:0] : 8'h00};
            q.push_back(e);
        end
    endtask

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    always @(negedge clk) begin
        exp_t cur;
        bit   busy;
        bit   er;
        string tag;
        if (!rst_n) begin
            chk({ram_ce_n, ram_we_n, ram_oe_n, ram_be_n} == 5'b11111, "R2 strobes", {ram_ce_n, ram_we_n, ram_oe_n, ram_be_n}, 5'b11111);
            chk(!rd_valid && rd_data == 0 && !ready, "R2 outputs", {rd_valid, ready, rd_data}, 0);
        end else begin
            busy = (q.size() > 0);
            if (busy) cur = q.pop_front();
            else begin cur = '0; cur.ce_n = 1; cur.we_n = 1; cur.oe_n = 1; cur.be_n = 2'b11; end
            er = (ecnt >= PW_C) && !busy;
            tag = cur.ce_n ? "R9 idle" : ((!cur.oe_n || cur.rdv) ? "R6 read" : "R3 write");
            chk(ready == er, (ecnt < PW_C) ? "R1 ready" : "R9 ready", ready, er);
            chk({ram_ce_n, ram_we_n, ram_oe_n} == {cur.ce_n, cur.we_n, cur.oe_n}, tag,
                {ram_ce_n, ram_we_n, ram_oe_n}, {cur.ce_n, cur.we_n, cur.oe_n});
            if (!cur.ce_n)
                chk({ram_be_n, ram_addr} == {cur.be_n, cur.addr}, "R8/R5 addr+lanes",
                    {ram_be_n, ram_addr}, {cur.be_n, cur.addr});
            if (cur.dchk) chk(ram_dq == cur.wd, "R4 bus data", ram_dq, cur.wd);
            chk(rd_valid == cur.rdv, "R7 rd_valid", rd_valid, cur.rdv);
            if (cur.rdv) chk(rd_data == cur.rd, "R7 rd_data", rd_data, cur.rd);
            if (req_valid && er) push_seq(req_write, req_addr, req_be, req_wdata);

            // RAM model: write window tracking and commit
            if (!ram_ce_n && !ram_we_n && ram_be_n != 2'b11) begin
                if (!prev_w) begin
                    wcnt = 1; stab = 1; last_dq = ram_dq; w_addr = ram_addr; w_be = ram_be_n;
                end else begin
                    wcnt++;
                    if (ram_dq == last_dq) stab++; else begin stab = 1; last_dq = ram_dq; end
                end
                prev_w = 1;
            end else if (prev_w) begin
                chk(wcnt >= PWE_C, "R10 pulse width", wcnt, PWE_C);
                chk(stab >= SD_C, "R4 data setup", stab, SD_C);
                chk(ram_dq == last_dq, "R4 data hold", ram_dq, last_dq);
                chk(ram_addr == w_addr, "R8 address hold", ram_addr, w_addr);
                if (!w_be[0]) ram_mem[w_addr][7:0]  = last_dq[7:0];
                if (!w_be[1]) ram_mem[w_addr][15:8] = last_dq[15:8];
                prev_w = 0;
            end
            // RAM model: access time tracking
            if (rd_act) begin
                rcnt = (rcnt > 0 && r_addr == ram_addr) ? rcnt + 1 : 1;
                r_addr = ram_addr;
            end else rcnt = 0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
        bit r;
        @(posedge clk); #1;
        req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        r = 0;
        while (!r) begin
            @(negedge clk); r = ready;
            @(posedge clk);
        end
        #1;
        req_valid = 0; req_addr = ~a; req_be = ~be; req_wdata = ~d; req_write = ~w;
    endtask

    task automatic poke_busy(input int n);
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = 18'h2AAAA; req_be = 2'b11; req_wdata = 16'hDEAD;
        repeat (n) @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1;
        repeat (100) @(posedge clk);
        poke_busy(3);                                       // R1/R9: ignored during power-up
        issue(1, 18'h00123, 2'b11, 16'hA55A);               // R3 full write
        issue(0, 18'h00123, 2'b11, 16'h0000);               // R6/R7 full read
        issue(1, 18'h00123, 2'b01, 16'h1234);               // R5 low lane only
        poke_busy(2);                                       // R9: ignored while busy
        issue(0, 18'h00123, 2'b11, 16'h0000);
        issue(1, 18'h00123, 2'b10, 16'h7700);               // R5 high lane only
        issue(0, 18'h00123, 2'b01, 16'h0000);               // R7 high lane returns zero
        issue(0, 18'h00123, 2'b10, 16'h0000);               // R7 low lane returns zero
        issue(1, 18'h00777, 2'b11, 16'h0F0F);
        issue(1, 18'h00777, 2'b00, 16'hFFFF);               // R5 no lane selected
        issue(0, 18'h00777, 2'b11, 16'h0000);
        issue(1, 18'h3FFFF, 2'b11, 16'hC3E1);               // boundary addresses
        issue(1, 18'h00000, 2'b11, 16'h5A01);
        issue(0, 18'h3FFFF, 2'b11, 16'h0000);
        poke_busy(1);
        issue(0, 18'h00000, 2'b11, 16'h0000);
        issue(0, 18'h00000, 2'b00, 16'h0000);               // R7 no lane: zero
        repeat (20) @(posedge clk);
        chk(q.size() == 0, "R9 drained", q.size(), 0);
        finish_run();
    end
endmodule